// File: doc/BRIEF.md
# Event Routing Channel

One channel of an on-chip event fabric. A 7-bit index in the channel's control word picks one signal out of a bank of event generator lines; index zero, or an index past the end of the bank, leaves the channel without a source. The chosen signal then reaches the channel output over one of three routes. The direct route samples it in the channel clock domain. The resynchronized route first passes it through a two-stage synchronizer. The pass-through route forwards the level with no clocking at all. On the two clocked routes an edge detector, set per channel to none, rising, falling or both, turns each qualifying transition into a single-cycle pulse.

The whole configuration sits in one 32-bit control word, written in a single access over a plain write-enable register port and always readable. The channel also drives a clock-request line. It can hold that line high whenever the channel is usable, or raise it only while a transition is moving through the clocked pipeline. A standby input can silence the channel unless the channel is marked to keep running in standby. A parameter gives the channel's position in the fabric. Positions 12 and above carry only the pass-through route.

Top module: `evt_channel`

## Requirements
- R1: The control word resets to 0x00008000. A write stores the written value masked with 0x0000CF7F and reads back the same way: bit 15 is the on-demand flag, bit 14 the run-in-standby flag, bits 11:10 the edge mode, bits 9:8 the route and bits 6:0 the source index. All other bits read as zero.
- R2: Source index 0, or any index not below the N_GEN parameter, selects no source, and the output stays low. Any other index k routes gen_in[k].
- R3: On the direct route (route 0), a source transition applied before clock edge k gives evt_out high for exactly the one cycle after edge k, provided the edge mode accepts that transition.
- R4: On the resynchronized route (route 1), the same pulse appears two cycles later, in the cycle after edge k+2, and it is one cycle wide.
- R5: Edge mode 0 yields no pulse, 1 only rising transitions, 2 only falling transitions and 3 both.
- R6: On the pass-through route (route 2), evt_out equals the selected source level combinationally, whatever the edge mode is.
- R7: Route value 3 disables the channel: evt_out and clk_req stay low, and the control word still reads back 3 in bits 9:8.
- R8: When the channel position parameter is 12 or more, routes 0 and 1 produce no output and no clock request. Route 2 works as in R6.
- R9: While standby is high and bit 14 is 0, evt_out and clk_req are low. With bit 14 at 1 the channel runs normally in standby.
- R10: With bit 15 at 0, clk_req is high exactly when the channel is usable: it has a valid source and a usable route, and standby does not silence it.
- R11: With bit 15 at 1, on a clocked route clk_req is high while the selected source differs from the last pipeline stage, or while the pipeline holds a transition not yet seen by the detector. On the pass-through route it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word readback |
| gen_in | input | N_GEN | Event generator lines |
| standby | input | 1 | Standby sleep indication |
| evt_out | output | 1 | Event output (pulse or level) |
| clk_req | output | 1 | Clock request |

## Verification
The pass-through route is swept with every source index, including zero and out-of-range values, against a walking-one pattern on the generator bank. This separates a correct index decode from off-by-one and aliasing faults. Both clocked routes are swept through all four edge modes, each with a rising and a falling stimulus. The pulse's position in the window tells the direct route's latency from the resynchronized one, and its presence tells the edge modes apart. Dedicated patterns cover the standby gating, the reserved route, a high-position channel and the two clock-request policies.

// File: rtl/evch_pkg.sv
package evch_pkg;

    localparam int          GEN_W        = 7;
    localparam int          CLK_CH_LIMIT = 12;
    localparam logic [31:0] CTRL_RESET   = 32'h0000_8000;
    localparam logic [31:0] CTRL_MASK    = 32'h0000_CF7F;

    typedef enum logic [1:0] {
        ROUTE_DIRECT  = 2'd0,
        ROUTE_RESYNC  = 2'd1,
        ROUTE_THROUGH = 2'd2,
        ROUTE_RSVD    = 2'd3
    } route_e;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_e;

    typedef struct packed {
        logic             on_demand;
        logic             stby_run;
        edge_e            edge_mode;
        route_e           route;
        logic [GEN_W-1:0] src_idx;
    } ctrl_t;

    function automatic ctrl_t decode_ctrl(input logic [31:0] w);
        ctrl_t c;
        c.on_demand = w[15];
        c.stby_run  = w[14];
        c.edge_mode = edge_e'(w[11:10]);
        c.route     = route_e'(w[9:8]);
        c.src_idx   = w[6:0];
        return c;
    endfunction

    function automatic logic edge_hit(input edge_e m, input logic cur, input logic prv);
        return (m[0] & cur & ~prv) | (m[1] & ~cur & prv);
    endfunction

endpackage

// File: rtl/evch_cfg_reg.sv
module evch_cfg_reg
    import evch_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output ctrl_t       ctrl
);

    logic [31:0] word_q;

    always_ff @(posedge clk) begin
        if (rst)     word_q <= CTRL_RESET;
        else if (we) word_q <= wdata & CTRL_MASK;
    end

    assign rdata = word_q;
    assign ctrl  = decode_ctrl(word_q);

    // R1: a write is visible, masked, on the following cycle
    p_readback_r1: assert property (@(posedge clk) disable iff (rst)
        we |=> (rdata == ($past(wdata) & CTRL_MASK)));

endmodule

// File: rtl/evch_src_mux.sv
module evch_src_mux
    import evch_pkg::*;
#(
    parameter int N_GEN = 128
) (
    input  logic [N_GEN-1:0] gen_in,
    input  logic [GEN_W-1:0] idx,
    output logic             src,
    output logic             valid
);

    always_comb begin
        src   = 1'b0;
        valid = 1'b0;
        for (int i = 0; i < N_GEN; i++) begin
            if (idx == GEN_W'(i) && i != 0) begin
                src   = gen_in[i];
                valid = 1'b1;
            end
        end
    end

endmodule

// File: rtl/evch_edge_det.sv
module evch_edge_det
    import evch_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  src,
    input  logic  resync,
    input  edge_e mode,
    output logic  pulse,
    output logic  pending
);

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   samp_d;
    logic                   samp_q;
    logic                   prev_q;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst)         chain_q[g] <= 1'b0;
            else if (g == 0) chain_q[g] <= src;
            else             chain_q[g] <= chain_q[(g == 0) ? 0 : g - 1];
        end
    end

    assign samp_d = resync ? chain_q[SYNC_STAGES-1] : src;

    always_ff @(posedge clk) begin
        if (rst) begin
            samp_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            samp_q <= samp_d;
            prev_q <= samp_q;
        end
    end

    assign pulse   = edge_hit(mode, samp_q, prev_q);
    assign pending = (src != prev_q) | (samp_q != prev_q)
                   | (resync & (chain_q != {SYNC_STAGES{prev_q}}));

endmodule

// File: rtl/evt_channel.sv
module evt_channel
    import evch_pkg::*;
#(
    parameter int N_GEN       = 128,
    parameter int CH_IDX      = 0,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic [N_GEN-1:0] gen_in,
    input  logic             standby,
    output logic             evt_out,
    output logic             clk_req
);

    localparam logic CLK_OK = (CH_IDX < CLK_CH_LIMIT);

    ctrl_t ctrl;
    logic  src, src_valid;
    logic  pulse, pending;
    logic  stby_off, route_ok, active, clocked;

    evch_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .ctrl  (ctrl)
    );

    evch_src_mux #(.N_GEN(N_GEN)) u_mux (
        .gen_in (gen_in),
        .idx    (ctrl.src_idx),
        .src    (src),
        .valid  (src_valid)
    );

    evch_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .src     (src),
        .resync  (ctrl.route == ROUTE_RESYNC),
        .mode    (ctrl.edge_mode),
        .pulse   (pulse),
        .pending (pending)
    );

    assign stby_off = standby & ~ctrl.stby_run;
    assign clocked  = (ctrl.route == ROUTE_DIRECT) || (ctrl.route == ROUTE_RESYNC);
    assign route_ok = (ctrl.route == ROUTE_THROUGH) || (clocked && CLK_OK);
    assign active   = route_ok & ~stby_off;

    always_comb begin
        if (!active)                         evt_out = 1'b0;
        else if (ctrl.route == ROUTE_THROUGH) evt_out = src;
        else                                 evt_out = pulse;
    end

    always_comb begin
        if (!ctrl.on_demand) clk_req = active & src_valid;
        else                 clk_req = active & clocked & pending;
    end

    // R9: standby without run-in-standby silences the channel
    p_standby_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (standby && !reg_rdata[14]) |-> (!evt_out && !clk_req));

    // R7: reserved route gives no output and no request
    p_rsvd_route_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[9:8] == 2'd3) |-> (!evt_out && !clk_req));

    // R2: no source on the pass-through route means no output
    p_no_src_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[9:8] == 2'd2 && reg_rdata[6:0] == 7'd0) |-> !evt_out);

    // R5: edge mode none emits nothing on a clocked route
    p_edge_none_r5: assert property (@(posedge clk) disable iff (rst)
        (!reg_rdata[9] && reg_rdata[11:10] == 2'd0) |-> !evt_out);

    // R8: high-position channels never drive a clocked route
    p_hi_channel_r8: assert property (@(posedge clk) disable iff (rst)
        (!CLK_OK && !reg_rdata[9]) |-> (!evt_out && !clk_req));

endmodule

// File: tb/evt_channel_tb.sv
module evt_channel_tb;

    localparam int NG = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_we = 1'b0, hi_we = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata, hi_rdata;
    logic [NG-1:0] gen_in = '0;
    logic          standby = 1'b0;
    logic          evt_out, clk_req, hi_evt, hi_req;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    evt_channel #(.N_GEN(NG), .CH_IDX(0)) u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .gen_in(gen_in), .standby(standby),
        .evt_out(evt_out), .clk_req(clk_req));

    evt_channel #(.N_GEN(NG), .CH_IDX(12)) u_dut_hi (
        .clk(clk), .rst(rst), .reg_we(hi_we), .reg_wdata(reg_wdata),
        .reg_rdata(hi_rdata), .gen_in(gen_in), .standby(standby),
        .evt_out(hi_evt), .clk_req(hi_req));

    function automatic logic [31:0] cw(input bit od, input bit sr, input int em,
                                       input int rt, input int g);
        return (32'(od) << 15) | (32'(sr) << 14) | (32'(em & 3) << 10)
             | (32'(rt & 3) << 8) | 32'(g & 127);
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] w);
        reg_we = 1'b1; reg_wdata = w; step(); reg_we = 1'b0;
    endtask

    task automatic wr_hi(input logic [31:0] w);
        hi_we = 1'b1; reg_wdata = w; step(); hi_we = 1'b0;
    endtask

    task automatic settle();
        repeat (6) step();
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();

        // R1 reset state
        chk("R1 reset word", reg_rdata, 32'h0000_8000);
        chk("R1 reset evt", evt_out, 0);
        chk("R1 reset req", clk_req, 0);
        wr(32'hFFFF_FFFF);
        chk("R1 mask all ones", reg_rdata, 32'h0000_CF7F);
        wr(32'h1234_5A85);
        chk("R1 mask pattern", reg_rdata, 32'h1234_5A85 & 32'h0000_CF7F);

        // R2 R6 R10 pass-through sweep over every source index
        for (int g = 0; g < 16; g++) begin
            wr(cw(0, 0, 0, 2, g));
            for (int j = 0; j < NG; j++) begin
                gen_in = NG'(1) << j;
                #1;
                chk("R2 R6 through index", evt_out, (g == j && g != 0 && g < NG));
                chk("R10 always-on request", clk_req, (g != 0 && g < NG));
            end
            gen_in = '0;
        end

        // R3 R4 R5 clocked routes, every edge mode, both directions
        for (int rt = 0; rt < 2; rt++) begin
            for (int em = 0; em < 4; em++) begin
                for (int dir = 0; dir < 2; dir++) begin
                    gen_in = '0;
                    gen_in[5] = (dir == 1);
                    wr(cw(0, 0, em, rt, 5));
                    settle();
                    gen_in[5] = (dir == 0);
                    for (int c = 1; c <= 5; c++) begin
                        step();
                        chk(rt == 0 ? "R3 R5 direct pulse" : "R4 R5 resync pulse",
                            evt_out,
                            (c == (rt == 0 ? 1 : 3)) && ((dir == 0) ? em[0] : em[1]));
                    end
                end
            end
        end

        // R6 pass-through ignores edge mode and holds the level
        gen_in = '0;
        wr(cw(0, 0, 3, 2, 4));
        gen_in[4] = 1'b1; #1;
        chk("R6 level now", evt_out, 1);
        step(); step();
        chk("R6 level held", evt_out, 1);
        gen_in = '0;

        // R7 reserved route
        wr(cw(0, 0, 1, 3, 5));
        chk("R7 readback", reg_rdata[9:8], 3);
        settle();
        gen_in[5] = 1'b1;
        for (int c = 1; c <= 5; c++) begin
            step();
            chk("R7 no event", evt_out, 0);
            chk("R7 no request", clk_req, 0);
        end
        gen_in = '0;

        // R8 high-position channel
        wr_hi(cw(0, 0, 1, 0, 5));
        settle();
        chk("R8 no request clocked", hi_req, 0);
        gen_in[5] = 1'b1;
        for (int c = 1; c <= 5; c++) begin
            step();
            chk("R8 no clocked event", hi_evt, 0);
        end
        wr_hi(cw(0, 0, 0, 2, 5));
        chk("R8 through works", hi_evt, 1);
        chk("R8 through request", hi_req, 1);
        gen_in = '0;

        // R9 standby gating
        standby = 1'b1;
        wr(cw(0, 0, 1, 0, 5));
        settle();
        chk("R9 request off", clk_req, 0);
        gen_in[5] = 1'b1;
        for (int c = 1; c <= 4; c++) begin
            step();
            chk("R9 silenced", evt_out, 0);
        end
        gen_in = '0;
        wr(cw(0, 1, 1, 0, 5));
        settle();
        chk("R9 run request", clk_req, 1);
        gen_in[5] = 1'b1;
        step();
        chk("R9 runs in standby", evt_out, 1);
        standby = 1'b0;
        gen_in = '0;

        // R10 no source means no always-on request
        wr(cw(0, 0, 1, 0, 0));
        chk("R10 no source", clk_req, 0);

        // R11 on-demand request, direct route
        wr(cw(1, 0, 1, 0, 5));
        settle();
        chk("R11 idle", clk_req, 0);
        gen_in[5] = 1'b1; #1;
        chk("R11 raise", clk_req, 1);
        step();
        chk("R11 in flight", clk_req, 1);
        step();
        chk("R11 done direct", clk_req, 0);
        gen_in = '0;

        // R11 resync route holds longer
        wr(cw(1, 0, 1, 1, 5));
        settle();
        gen_in[5] = 1'b1;
        repeat (3) step();
        chk("R11 resync in flight", clk_req, 1);
        step();
        chk("R11 resync done", clk_req, 0);

        // R11 pass-through never requests on demand
        wr(cw(1, 0, 0, 2, 5));
        chk("R11 through", clk_req, 0);
        chk("R11 through level", evt_out, 1);
        gen_in = '0;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule